// File: doc/BRIEF.md
# Serial port modem-line and wake-up controller

This block sits on the equipment side of an asynchronous serial link and owns the three modem status lines it presents to the terminal. The three lines are clear-to-send, data-set-ready and ring indicator. All three are active low. It works beside an external receiver shifter. From that shifter it takes a strobe for each completed byte. It also watches the raw incoming data line.

With power saving enabled, the port falls asleep after a programmable stretch without received bytes. While asleep it holds clear-to-send OFF. A falling edge on the data line starts a wake-up of fixed length. The byte that caused the wake-up is lost, and a flag reports this. Clear-to-send returns to ON only once wake-up completes.

Data-set-ready is either held permanently ON or follows the command/data mode, which is set by entry and exit pulses. The ring indicator produces one ON pulse of fixed length for each message-arrival event.

The power sequencer has three states, and its transitions are named below:
- `ST_AWAKE`: running.
- `ST_IDLE`: asleep.
- `ST_WAKING`: wake-up in progress.

| Transition | From | To | Condition |
|---|---|---|---|
| doze | `ST_AWAKE` | `ST_IDLE` | inactivity timer expires |
| rouse | `ST_IDLE` | `ST_WAKING` | falling edge on the data line |
| ready | `ST_WAKING` | `ST_AWAKE` | wake timer expires |
| bypass | `ST_IDLE` or `ST_WAKING` | `ST_AWAKE` | power saving disabled |

The ring timer has two states, `RG_OFF` and `RG_ON`. The data-set-ready tracker has two states, `MD_CMD` and `MD_DATA`.

Top module: `dce_line_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the outputs to their start values on the next clock edge:
  - `cts_n` = 0 and `ri_n` = 1;
  - `awake` = 1 and `first_byte_lost` = 0;
  - mode set to command, so `dsr_n` = 0 when `dsr_follow` = 0 and `dsr_n` = 1 when `dsr_follow` = 1.
- R2: With `dsr_follow` = 0 (always-on mode), `dsr_n` is 0 whatever mode events arrive.
- R3: With `dsr_follow` = 1, `dsr_n` is 1 in command mode and 0 in data mode. A `data_enter` pulse selects data mode from the next edge, and a `data_exit` pulse selects command mode from the next edge. When both pulses arrive in the same cycle, exit wins.
- R4: An `sms_evt` pulse sampled at an edge drives `ri_n` to 0 from that edge for exactly RING_CYC cycles, after which `ri_n` returns to 1. A new pulse during the ON time restarts the full length.
- R5: With `psave_en` = 1, the port leaves `ST_AWAKE` after IDLE_CYC consecutive edges with no `rx_byte`, counted from reset or from the last `rx_byte`. After that, `awake` = 0 and `cts_n` = 1.
- R6: An `rx_byte` strobe while awake restarts the inactivity count from zero.
- R7: In `ST_IDLE`, a high-to-low change of `txd_in` between two edges enters `ST_WAKING`. The port then keeps `awake` = 0 and `cts_n` = 1 for WAKE_CYC cycles before returning to `ST_AWAKE`. A `txd_in` held high does not wake the port.
- R8: The wake edge sets `first_byte_lost` to 1. `rx_byte` strobes during `ST_IDLE` or `ST_WAKING` are discarded: they change neither the state, the wake timing nor the flag. The flag clears at the edge of the first `rx_byte` accepted while awake.
- R9: With `psave_en` = 0, `awake` = 1 and `cts_n` = 0. Clearing `psave_en` while asleep or waking returns the port to `ST_AWAKE` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsr_follow | input | 1 | 0: data-set-ready always ON; 1: follows command/data mode |
| psave_en | input | 1 | Power-saving enable |
| data_enter | input | 1 | Pulse: enter data mode |
| data_exit | input | 1 | Pulse: return to command mode |
| sms_evt | input | 1 | Pulse: message arrival, starts ring pulse |
| rx_byte | input | 1 | Strobe: receiver completed a byte |
| txd_in | input | 1 | Incoming data line, idle high |
| cts_n | output | 1 | Clear-to-send, active low |
| dsr_n | output | 1 | Data-set-ready, active low |
| ri_n | output | 1 | Ring indicator, active low |
| awake | output | 1 | Port is in the running state |
| first_byte_lost | output | 1 | The byte that woke the port was discarded |

## Verification
The bench builds the block with these parameter values:

| Parameter | Value |
|---|---|
| IDLE_CYC | 8 |
| WAKE_CYC | 4 |
| RING_CYC | 6 |

These values bring several corner cases within a few dozen cycles:
- the exact expiry edge of the inactivity timer, both from reset and after a restarting strobe;
- the last cycle of the wake window, including a discarded strobe inside it;
- the retriggered ring pulse.

A vector table walks the data-set-ready modes through every combination of entry and exit pulses.

// File: rtl/dce_ctl_pkg.sv
package dce_ctl_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_WAKING = 2'd2
    } pwr_state_t;

    typedef enum logic {
        RG_OFF = 1'b0,
        RG_ON  = 1'b1
    } ring_state_t;

    typedef enum logic {
        MD_CMD  = 1'b0,
        MD_DATA = 1'b1
    } line_mode_t;

endpackage

// File: rtl/dce_power_fsm.sv
module dce_power_fsm
    import dce_ctl_pkg::*;
#(
    parameter int unsigned IDLE_CYC = 2000,
    parameter int unsigned WAKE_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psave_en,
    input  logic rx_byte,
    input  logic txd_in,
    output logic cts_n,
    output logic awake,
    output logic first_byte_lost
);
    localparam int unsigned MAX_CYC = (IDLE_CYC > WAKE_CYC) ? IDLE_CYC : WAKE_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC) + 1;
    localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);

    pwr_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             txd_q;
    logic             lost, lost_nxt;
    logic             txd_fall;

    assign txd_fall = txd_q & ~txd_in;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_AWAKE;
            cnt   <= '0;
            txd_q <= 1'b1;
            lost  <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            txd_q <= txd_in;
            lost  <= lost_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        lost_nxt  = lost;
        unique case (state)
            ST_AWAKE: begin
                if (rx_byte) begin
                    lost_nxt = 1'b0;
                end
                if (!psave_en || rx_byte) begin
                    cnt_nxt = '0;
                end else if (cnt == IDLE_LAST) begin
                    state_nxt = ST_IDLE;         // doze
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                cnt_nxt = '0;
                if (!psave_en) begin
                    state_nxt = ST_AWAKE;        // bypass
                end else if (txd_fall) begin
                    state_nxt = ST_WAKING;       // rouse
                    lost_nxt  = 1'b1;
                end
            end
            ST_WAKING: begin
                if (!psave_en) begin
                    state_nxt = ST_AWAKE;        // bypass
                    cnt_nxt   = '0;
                end else if (cnt == WAKE_LAST) begin
                    state_nxt = ST_AWAKE;        // ready
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                state_nxt = ST_AWAKE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        awake           = (state == ST_AWAKE);
        cts_n           = (state != ST_AWAKE);
        first_byte_lost = lost;
    end

    p_doze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && psave_en && !rx_byte && cnt == IDLE_LAST) |=> (state == ST_IDLE));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && rx_byte) |=> (state == ST_AWAKE && cnt == '0));

    p_rouse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && psave_en && txd_fall) |=> (state == ST_WAKING && lost));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && psave_en && !txd_fall) |=> (state == ST_IDLE));

    p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_AWAKE && lost) |=> lost);

    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !psave_en |=> (awake && !cts_n));

endmodule

// File: rtl/dce_ring_timer.sv
module dce_ring_timer
    import dce_ctl_pkg::*;
#(
    parameter int unsigned RING_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sms_evt,
    output logic ri_n
);
    localparam int unsigned CNT_W = $clog2(RING_CYC) + 1;
    localparam logic [CNT_W-1:0] RING_LAST = CNT_W'(RING_CYC - 1);

    ring_state_t      rstate, rstate_nxt;
    logic [CNT_W-1:0] rcnt, rcnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rstate <= RG_OFF;
            rcnt   <= '0;
        end else begin
            rstate <= rstate_nxt;
            rcnt   <= rcnt_nxt;
        end
    end

    always_comb begin
        rstate_nxt = rstate;
        rcnt_nxt   = rcnt;
        unique case (rstate)
            RG_OFF: begin
                rcnt_nxt = '0;
                if (sms_evt) begin
                    rstate_nxt = RG_ON;          // ring
                end
            end
            RG_ON: begin
                if (sms_evt) begin
                    rcnt_nxt = '0;               // retrigger
                end else if (rcnt == RING_LAST) begin
                    rstate_nxt = RG_OFF;         // ring end
                    rcnt_nxt   = '0;
                end else begin
                    rcnt_nxt = rcnt + 1'b1;
                end
            end
            default: begin
                rstate_nxt = RG_OFF;
                rcnt_nxt   = '0;
            end
        endcase
    end

    always_comb begin
        ri_n = (rstate != RG_ON);
    end

    p_ring_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sms_evt |=> !ri_n);

    p_ring_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rstate == RG_ON && !sms_evt && rcnt == RING_LAST) |=> ri_n);

endmodule

// File: rtl/dce_dsr_track.sv
module dce_dsr_track
    import dce_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dsr_follow,
    input  logic data_enter,
    input  logic data_exit,
    output logic dsr_n
);
    line_mode_t mode, mode_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MD_CMD;
        end else begin
            mode <= mode_nxt;
        end
    end

    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            MD_CMD:  if (data_enter && !data_exit) mode_nxt = MD_DATA;  // enter
            MD_DATA: if (data_exit)                mode_nxt = MD_CMD;   // leave
            default: mode_nxt = MD_CMD;
        endcase
    end

    always_comb begin
        dsr_n = dsr_follow && (mode == MD_CMD);
    end

    p_always_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dsr_follow |-> !dsr_n);

    p_exit_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_exit |=> (mode == MD_CMD));

    p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_enter && !data_exit) |=> (mode == MD_DATA));

endmodule

// File: rtl/dce_line_ctrl.sv
module dce_line_ctrl #(
    parameter int unsigned IDLE_CYC = 2000,
    parameter int unsigned WAKE_CYC = 200,
    parameter int unsigned RING_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dsr_follow,
    input  logic psave_en,
    input  logic data_enter,
    input  logic data_exit,
    input  logic sms_evt,
    input  logic rx_byte,
    input  logic txd_in,
    output logic cts_n,
    output logic dsr_n,
    output logic ri_n,
    output logic awake,
    output logic first_byte_lost
);

    dce_power_fsm #(
        .IDLE_CYC(IDLE_CYC),
        .WAKE_CYC(WAKE_CYC)
    ) u_power (
        .clk             (clk),
        .rst_n           (rst_n),
        .psave_en        (psave_en),
        .rx_byte         (rx_byte),
        .txd_in          (txd_in),
        .cts_n           (cts_n),
        .awake           (awake),
        .first_byte_lost (first_byte_lost)
    );

    dce_ring_timer #(
        .RING_CYC(RING_CYC)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .sms_evt (sms_evt),
        .ri_n    (ri_n)
    );

    dce_dsr_track u_dsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .dsr_follow (dsr_follow),
        .data_enter (data_enter),
        .data_exit  (data_exit),
        .dsr_n      (dsr_n)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!cts_n && ri_n && awake && !first_byte_lost));

endmodule

// File: tb/test_dce_line_ctrl.sv
module test_dce_line_ctrl;
    localparam int unsigned IDLE_CYC = 8;
    localparam int unsigned WAKE_CYC = 4;
    localparam int unsigned RING_CYC = 6;
    localparam int unsigned NVEC     = 9;
    // each entry: {dsr_follow, data_enter, data_exit, expected dsr_n}
    localparam logic [3:0] DSR_VEC [NVEC] = '{
        4'b1001, 4'b1100, 4'b1000, 4'b0010, 4'b1001,
        4'b1111, 4'b0100, 4'b1000, 4'b1011
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dsr_follow = 1'b0, psave_en = 1'b0, data_enter = 1'b0, data_exit = 1'b0;
    logic sms_evt = 1'b0, rx_byte = 1'b0, txd_in = 1'b1;
    logic cts_n, dsr_n, ri_n, awake, first_byte_lost;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    dce_line_ctrl #(
        .IDLE_CYC(IDLE_CYC), .WAKE_CYC(WAKE_CYC), .RING_CYC(RING_CYC)
    ) i_dce_line_ctrl (
        .clk(clk), .rst_n(rst_n), .dsr_follow(dsr_follow), .psave_en(psave_en),
        .data_enter(data_enter), .data_exit(data_exit), .sms_evt(sms_evt),
        .rx_byte(rx_byte), .txd_in(txd_in), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .awake(awake), .first_byte_lost(first_byte_lost)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state in follow mode
        dsr_follow = 1'b1;
        do_reset();
        check("R1", "cts_n", cts_n, 1'b0);
        check("R1", "ri_n", ri_n, 1'b1);
        check("R1", "awake", awake, 1'b1);
        check("R1", "first_byte_lost", first_byte_lost, 1'b0);
        check("R1", "dsr_n follow", dsr_n, 1'b1);
        dsr_follow = 1'b0;
        #0;
        check("R1", "dsr_n always", dsr_n, 1'b0);

        // R2/R3: table of mode events
        for (int i = 0; i < int'(NVEC); i++) begin
            dsr_follow = DSR_VEC[i][3];
            data_enter = DSR_VEC[i][2];
            data_exit  = DSR_VEC[i][1];
            step();
            data_enter = 1'b0;
            data_exit  = 1'b0;
            check(DSR_VEC[i][3] ? "R3" : "R2", "dsr_n vector", dsr_n, DSR_VEC[i][0]);
        end

        // R4: ring pulse length
        sms_evt = 1'b1;
        step();
        sms_evt = 1'b0;
        check("R4", "ri_n start", ri_n, 1'b0);
        for (int k = 1; k < int'(RING_CYC); k++) step();
        check("R4", "ri_n last on cycle", ri_n, 1'b0);
        step();
        check("R4", "ri_n end", ri_n, 1'b1);
        // R4: retrigger
        sms_evt = 1'b1;
        step();
        sms_evt = 1'b0;
        step(); step();
        sms_evt = 1'b1;
        step();
        sms_evt = 1'b0;
        for (int k = 1; k < int'(RING_CYC); k++) step();
        check("R4", "ri_n retrigger still on", ri_n, 1'b0);
        step();
        check("R4", "ri_n retrigger end", ri_n, 1'b1);

        // R5: inactivity from reset
        psave_en = 1'b1;
        do_reset();
        for (int k = 1; k < int'(IDLE_CYC); k++) step();
        check("R5", "awake before expiry", awake, 1'b1);
        step();
        check("R5", "awake after expiry", awake, 1'b0);
        check("R5", "cts_n after expiry", cts_n, 1'b1);

        // R6: strobe restarts timer
        do_reset();
        for (int k = 0; k < 5; k++) step();
        rx_byte = 1'b1;
        step();
        rx_byte = 1'b0;
        for (int k = 1; k < int'(IDLE_CYC); k++) step();
        check("R6", "awake after restart", awake, 1'b1);
        step();
        check("R6", "idle after restarted count", awake, 1'b0);

        // R7: high line keeps idle; R8: strobe in idle ignored
        step(); step();
        rx_byte = 1'b1;
        step();
        rx_byte = 1'b0;
        check("R7", "idle with line high", awake, 1'b0);
        check("R8", "lost flag untouched in idle", first_byte_lost, 1'b0);

        // R7: falling edge wakes after WAKE_CYC cycles
        txd_in = 1'b0;
        step();
        txd_in = 1'b1;
        check("R7", "awake at wake start", awake, 1'b0);
        check("R7", "cts_n at wake start", cts_n, 1'b1);
        check("R8", "lost flag set", first_byte_lost, 1'b1);
        step();
        rx_byte = 1'b1;                      // discarded strobe inside wake window
        step();
        rx_byte = 1'b0;
        step();
        check("R7", "awake last wake cycle", awake, 1'b0);
        check("R8", "lost flag held", first_byte_lost, 1'b1);
        step();
        check("R7", "awake after wake", awake, 1'b1);
        check("R7", "cts_n after wake", cts_n, 1'b0);
        check("R8", "lost flag held until byte", first_byte_lost, 1'b1);
        rx_byte = 1'b1;
        step();
        rx_byte = 1'b0;
        check("R8", "lost flag cleared", first_byte_lost, 1'b0);

        // R9: disable power saving while idle
        for (int k = 0; k < int'(IDLE_CYC); k++) step();
        check("R9", "idle before disable", awake, 1'b0);
        psave_en = 1'b0;
        step();
        check("R9", "awake after disable", awake, 1'b1);
        for (int k = 0; k < 3 * int'(IDLE_CYC); k++) step();
        check("R9", "cts_n stays on", cts_n, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule